// File: doc/BRIEF.md
# Interruptible Multi-Channel Refresh Sequencer

This block keeps a bank of held analog outputs refreshed from a small code memory. It walks the memory one channel per sequencer step. During the step it places the stored code on a shared converter bus, and at the end of the step it issues a one-cycle sample strobe with the channel number, so every held output is rewritten in turn and the walk wraps around. The step length comes either from an internal divider of the system clock or from an external step clock, which is counted down by four.

Serial traffic takes priority over the refresh. A frame-start pulse freezes the walk and remembers the channel it was working on, and a frame-end pulse lets it go again. In immediate mode the sequencer first finishes the step in progress, then spends one step on the channel that was just written, and then returns to the channel it left. In burst mode it returns straight to that channel and lets new values appear as the walk reaches them.

After reset the block runs a fill pass that strobes every channel once, in order, with a fixed mid-range code. This pass always uses the internal step clock, and no frame pulse can disturb it. A busy flag stays high for the whole pass and is meant to gate the serial receiver's memory writes.

Top module: `refresh_seq`

## Requirements
- R1: While `rst_n` is low, `busy` is 1, `sh_strobe` is 0 and `code_out` is 0x4F3.
- R2: After reset is released, channels 0, 1, ... 31 are strobed in that order with `code_out` equal to 0x4F3. `busy` stays 1 throughout and drops in the same cycle as the strobe for channel 31.
- R3: During the fill pass the step is always `STEP_DIV` system clocks, even when an external step clock is selected and stopped. Frame pulses and mode inputs arriving during the pass change neither the order nor the codes.
- R4: Outside the fill pass and frames, the strobed channel advances by one per step, wrapping from 31 to 0. At each strobe `code_out` equals the memory word at that channel.
- R5: `sh_strobe` is high for exactly one system clock. `code_out` does not change in the strobe cycle or in the cycle before it.
- R6: With the internal step clock selected (`ext_sel_pin` and `ext_sel_bit` both 0), consecutive strobes are exactly `STEP_DIV` system clocks apart.
- R7: The external step clock is selected when `ext_sel_pin` or `ext_sel_bit` is 1. A step then lasts four rising edges of `ext_clk`, the internal divider stops, and a stopped `ext_clk` produces no strobe at all.
- R8: After a `frame_start` pulse outside the fill pass, no strobe occurs until the next `frame_end`. The channel being handled when the pause began is remembered.
- R9: When `imm_pin` or `imm_bit` is 1 at `frame_end`, the next strobe is for `last_addr` and shows the new memory word. It occurs at most 2*`STEP_DIV`+1 clocks after `frame_end`. The walk then resumes at the interrupted channel.
- R10: When `imm_pin` and `imm_bit` are both 0 at `frame_end`, the next strobe is the interrupted channel. All 32 channels, new values included, are strobed within 33 steps of `frame_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; its release starts the fill pass |
| ext_clk | input | 1 | External step clock, already synchronous to `clk` |
| ext_sel_pin | input | 1 | External step clock request from a pin |
| ext_sel_bit | input | 1 | External step clock request from the last serial word |
| imm_pin | input | 1 | Immediate-mode request from a pin |
| imm_bit | input | 1 | Immediate-mode request from the last serial word |
| frame_start | input | 1 | One-cycle pulse when chip select falls |
| frame_end | input | 1 | One-cycle pulse when chip select rises |
| last_addr | input | 5 | Channel address of the last word written |
| mem_rd_addr | output | 5 | Code memory read address |
| mem_rd_data | input | 12 | Code memory read data (combinational read) |
| code_out | output | 12 | Code bus to the shared converter |
| sh_addr | output | 5 | Channel selected for the sample strobe |
| sh_strobe | output | 1 | One-cycle sample strobe for `sh_addr` |
| busy | output | 1 | High during the fill pass; gates serial writes |

## Verification
A wrong internal channel register shows up on `sh_addr` at the next strobe, within one step, or within two steps of `frame_end` when the resume point or immediate target is wrong. A step divider or external edge counter that loses count shows as a strobe spacing different from `STEP_DIV` or 16 clocks at the very next strobe. A code register loaded at the wrong time or from the wrong address shows as a wrong `code_out` at that channel's strobe, so within one pass of 32 steps. A fill pass that leaks frame effects or exits early shows as a wrong order or a `busy` edge that does not line up with channel 31.

// File: rtl/refresh_seq_pkg.sv
// Shared types and helpers for the refresh sequencer.
// Assumes nothing beyond a standard elaborator.
package refresh_seq_pkg;

    // Sequencer phases: fill pass, normal walk, paused by a frame,
    // waiting out the interrupted step before restarting.
    typedef enum logic [1:0] {
        SEQ_FILL   = 2'd0,
        SEQ_RUN    = 2'd1,
        SEQ_HOLD   = 2'd2,
        SEQ_FINISH = 2'd3
    } seq_state_e;

    // Address width for n entries, never below one bit.
    function automatic int unsigned addr_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rseq_step_gen.sv
// Step tick generator.
// Makes a one-cycle tick per sequencer step, either from an internal
// divider of the system clock or from every EXT_DIV-th rising edge of
// an external step clock. Assumes ext_clk is already synchronous to clk.
// force_int overrides the selection (used during the fill pass).
module rseq_step_gen #(
    parameter int unsigned STEP_DIV = 2000,
    parameter int unsigned EXT_DIV  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_int,
    input  logic ext_sel,
    input  logic ext_clk,
    output logic step_tick
);
    localparam int unsigned IW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
    localparam int unsigned EW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;
    localparam logic [IW-1:0] INT_LAST = IW'(STEP_DIV - 1);
    localparam logic [EW-1:0] EXT_LAST = EW'(EXT_DIV - 1);

    logic          use_int;
    logic [IW-1:0] int_cnt;
    logic [EW-1:0] ext_cnt;
    logic          ext_q;
    logic          ext_rise;

    assign use_int  = force_int | ~ext_sel;
    assign ext_rise = ext_clk & ~ext_q;

    // Internal divider; held at zero while the external clock is in use.
    always_ff @(posedge clk) begin
        if (!rst_n || !use_int) begin
            int_cnt <= '0;
        end else if (int_cnt == INT_LAST) begin
            int_cnt <= '0;
        end else begin
            int_cnt <= int_cnt + 1'b1;
        end
    end

    // Previous level of the external clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
        end else begin
            ext_q <= ext_clk;
        end
    end

    // External edge counter; held at zero while the internal divider runs.
    always_ff @(posedge clk) begin
        if (!rst_n || use_int) begin
            ext_cnt <= '0;
        end else if (ext_rise) begin
            ext_cnt <= (ext_cnt == EXT_LAST) ? '0 : ext_cnt + 1'b1;
        end
    end

    // Tick selection between the two step sources.
    always_comb begin
        if (use_int) begin
            step_tick = (int_cnt == INT_LAST);
        end else begin
            step_tick = ext_rise && (ext_cnt == EXT_LAST);
        end
    end

endmodule

// File: rtl/rseq_sched.sv
// Channel scheduler.
// Decides which channel each step handles, issues the end-of-step
// strobe, pauses on frames, and runs the uninterruptible fill pass after
// reset. Assumes frame_start/frame_end are one-cycle pulses and that a
// step lasts at least two system clocks.
module rseq_sched
    import refresh_seq_pkg::*;
#(
    parameter int unsigned CH_COUNT = 32,
    localparam int unsigned AW = addr_bits(CH_COUNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_tick,
    input  logic          frame_start,
    input  logic          frame_end,
    input  logic          imm_req,
    input  logic [AW-1:0] tgt_addr,
    output logic [AW-1:0] cur_ch,
    output logic          load_code,
    output logic          sh_strobe,
    output logic [AW-1:0] sh_addr,
    output logic          busy
);
    localparam logic [AW-1:0] LAST_CH = AW'(CH_COUNT - 1);

    seq_state_e    state_q;
    logic [AW-1:0] cur_q;
    logic [AW-1:0] nxt_ch;
    logic [AW-1:0] resume_q;
    logic [AW-1:0] tgt_q;
    logic          imm_step_q;
    logic          wait_imm_q;
    logic          strobe_q;
    logic [AW-1:0] addr_q;
    logic          load_q;

    // Next channel in the walk; natural wrap when the count fills the field.
    generate
        if ((1 << AW) == CH_COUNT) begin : g_pow2_wrap
            assign nxt_ch = cur_q + 1'b1;
        end else begin : g_cmp_wrap
            assign nxt_ch = (cur_q == LAST_CH) ? '0 : cur_q + 1'b1;
        end
    endgenerate

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_FILL;
            cur_q      <= '0;
            resume_q   <= '0;
            tgt_q      <= '0;
            imm_step_q <= 1'b0;
            wait_imm_q <= 1'b0;
            strobe_q   <= 1'b0;
            addr_q     <= '0;
            load_q     <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            load_q   <= 1'b0;
            unique case (state_q)
                SEQ_FILL: begin
                    if (step_tick) begin
                        strobe_q <= 1'b1;
                        addr_q   <= cur_q;
                        if (cur_q == LAST_CH) begin
                            state_q <= SEQ_RUN;
                            cur_q   <= '0;
                            load_q  <= 1'b1;
                        end else begin
                            cur_q <= nxt_ch;
                        end
                    end
                end
                SEQ_RUN: begin
                    if (frame_start) begin
                        state_q    <= SEQ_HOLD;
                        resume_q   <= imm_step_q ? resume_q : cur_q;
                        imm_step_q <= 1'b0;
                    end else if (step_tick) begin
                        strobe_q <= 1'b1;
                        addr_q   <= cur_q;
                        load_q   <= 1'b1;
                        if (imm_step_q) begin
                            cur_q      <= resume_q;
                            imm_step_q <= 1'b0;
                        end else begin
                            cur_q <= nxt_ch;
                        end
                    end
                end
                SEQ_HOLD: begin
                    if (frame_end) begin
                        state_q    <= SEQ_FINISH;
                        wait_imm_q <= imm_req;
                        tgt_q      <= tgt_addr;
                    end
                end
                SEQ_FINISH: begin
                    if (frame_start) begin
                        state_q <= SEQ_HOLD;
                    end else if (step_tick) begin
                        state_q    <= SEQ_RUN;
                        cur_q      <= wait_imm_q ? tgt_q : resume_q;
                        imm_step_q <= wait_imm_q;
                        load_q     <= 1'b1;
                    end
                end
                default: state_q <= SEQ_FILL;
            endcase
        end
    end

    assign cur_ch    = cur_q;
    assign load_code = load_q;
    assign sh_strobe = strobe_q;
    assign sh_addr   = addr_q;
    assign busy      = (state_q == SEQ_FILL);

endmodule

// File: rtl/rseq_code_reg.sv
// Code bus register.
// Captures the memory word for the current channel one cycle after the
// channel changes, then holds it for the rest of the step. Resets to the
// fill code, which stays on the bus during the whole fill pass.
module rseq_code_reg #(
    parameter int unsigned CODE_W = 12,
    parameter logic [CODE_W-1:0] FILL_CODE = 12'h4F3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_code,
    input  logic [CODE_W-1:0] rd_data,
    output logic [CODE_W-1:0] code_out
);
    // Load on request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out <= FILL_CODE;
        end else if (load_code) begin
            code_out <= rd_data;
        end
    end

endmodule

// File: rtl/refresh_seq.sv
// Interruptible multi-channel refresh sequencer (top).
// Merges the pin and serial-bit mode requests (a 1 on either wins),
// forces the internal step clock during the fill pass, and connects the
// step generator, scheduler and code register. Assumes a memory with a
// combinational read port and a step of at least two system clocks.
module refresh_seq
    import refresh_seq_pkg::*;
#(
    parameter int unsigned CH_COUNT = 32,
    parameter int unsigned CODE_W   = 12,
    parameter int unsigned STEP_DIV = 2000,
    parameter int unsigned EXT_DIV  = 4,
    parameter logic [CODE_W-1:0] FILL_CODE = 12'h4F3,
    localparam int unsigned AW = addr_bits(CH_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic              ext_sel_pin,
    input  logic              ext_sel_bit,
    input  logic              imm_pin,
    input  logic              imm_bit,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic [AW-1:0]     last_addr,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic [CODE_W-1:0] mem_rd_data,
    output logic [CODE_W-1:0] code_out,
    output logic [AW-1:0]     sh_addr,
    output logic              sh_strobe,
    output logic              busy
);
    logic step_tick;
    logic load_code;
    logic ext_sel;
    logic imm_req;

    assign ext_sel = ext_sel_pin | ext_sel_bit;
    assign imm_req = imm_pin | imm_bit;

    rseq_step_gen #(
        .STEP_DIV (STEP_DIV),
        .EXT_DIV  (EXT_DIV)
    ) step_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_int (busy),
        .ext_sel   (ext_sel),
        .ext_clk   (ext_clk),
        .step_tick (step_tick)
    );

    rseq_sched #(
        .CH_COUNT (CH_COUNT)
    ) sched_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_tick   (step_tick),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .imm_req     (imm_req),
        .tgt_addr    (last_addr),
        .cur_ch      (mem_rd_addr),
        .load_code   (load_code),
        .sh_strobe   (sh_strobe),
        .sh_addr     (sh_addr),
        .busy        (busy)
    );

    rseq_code_reg #(
        .CODE_W    (CODE_W),
        .FILL_CODE (FILL_CODE)
    ) code_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_code (load_code),
        .rd_data   (mem_rd_data),
        .code_out  (code_out)
    );

endmodule

// File: rtl/refresh_seq_chk.sv
// Property checker for the refresh sequencer, bound to its top.
// Tracks the fill order and the pause window with its own state.
module refresh_seq_chk
    import refresh_seq_pkg::*;
#(
    parameter int unsigned CH_COUNT = 32,
    parameter int unsigned CODE_W   = 12,
    parameter logic [CODE_W-1:0] FILL_CODE = 12'h4F3,
    localparam int unsigned AW = addr_bits(CH_COUNT)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              frame_end,
    input logic              busy,
    input logic              sh_strobe,
    input logic [AW-1:0]     sh_addr,
    input logic [CODE_W-1:0] code_out
);
    localparam logic [AW-1:0] LAST_CH = AW'(CH_COUNT - 1);

    logic [AW-1:0] fill_cnt;
    logic          paused_q;

    // Expected channel of the next fill strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
        end else if (busy && sh_strobe) begin
            fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // Pause window as seen from the frame pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paused_q <= 1'b0;
        end else if (frame_start && !busy) begin
            paused_q <= 1'b1;
        end else if (frame_end) begin
            paused_q <= 1'b0;
        end
    end

    assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sh_strobe |=> !sh_strobe);

    assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sh_strobe |-> $stable(code_out));

    assert_fill_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sh_strobe) |-> (code_out == FILL_CODE));

    assert_fill_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sh_strobe) |-> (sh_addr == fill_cnt));

    assert_fill_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (sh_strobe && sh_addr == LAST_CH));

    assert_pause_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        paused_q |-> !sh_strobe);

endmodule

bind refresh_seq refresh_seq_chk #(
    .CH_COUNT  (CH_COUNT),
    .CODE_W    (CODE_W),
    .FILL_CODE (FILL_CODE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .busy        (busy),
    .sh_strobe   (sh_strobe),
    .sh_addr     (sh_addr),
    .code_out    (code_out)
);

// File: tb/refresh_seq_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue the expected strobes, and a
// monitor pops and compares them on every strobe.
module refresh_seq_tb_top;
    localparam int DIV     = 8;
    localparam int CH      = 32;
    localparam int EXT_GAP = 16;

    typedef struct {
        logic [4:0]  a;
        logic [11:0] c;
        string       r;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk;
    logic        ext_sel_pin = 1'b0;
    logic        ext_sel_bit = 1'b0;
    logic        imm_pin = 1'b0;
    logic        imm_bit = 1'b0;
    logic        frame_start = 1'b0;
    logic        frame_end = 1'b0;
    logic [4:0]  last_addr = '0;
    logic [4:0]  mem_rd_addr;
    logic [11:0] mem_rd_data;
    logic [11:0] code_out;
    logic [4:0]  sh_addr;
    logic        sh_strobe;
    logic        busy;

    logic [11:0] mem [CH];
    exp_t        q[$];

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    strobe_cyc = 0;
    int    fe_cyc = 0;
    int    n_strobe = 0;
    int    last_seen = 0;
    int    exp_gap = 0;
    bit    gap_arm = 0;
    string gap_req = "R6";
    bit    ext_run = 0;
    bit    done = 0;
    logic        prev_s = 1'b0;
    logic [11:0] prev_code = '0;

    assign mem_rd_data = mem[mem_rd_addr];

    refresh_seq #(.STEP_DIV(DIV)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_clk     (ext_clk),
        .ext_sel_pin (ext_sel_pin),
        .ext_sel_bit (ext_sel_bit),
        .imm_pin     (imm_pin),
        .imm_bit     (imm_bit),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .last_addr   (last_addr),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .code_out    (code_out),
        .sh_addr     (sh_addr),
        .sh_strobe   (sh_strobe),
        .busy        (busy)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc++;

    // External step clock: toggles every two system clocks when enabled.
    initial begin
        ext_clk = 1'b0;
        forever begin
            @(posedge clk);
            @(posedge clk);
            #1;
            if (ext_run) ext_clk = ~ext_clk;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares every strobe against the scoreboard queue.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && sh_strobe) begin
            chk(!prev_s, "R5", "strobe width", 2, 1);
            chk(code_out == prev_code, "R5", "code moved at strobe",
                int'(code_out), int'(prev_code));
            if (q.size() == 0) begin
                chk(0, "R8", "unexpected strobe channel", int'(sh_addr), 255);
            end else begin
                e = q.pop_front();
                chk(sh_addr == e.a, e.r, "strobe channel", int'(sh_addr), int'(e.a));
                chk(code_out == e.c, e.r, "code at strobe", int'(code_out), int'(e.c));
            end
            if (gap_arm && exp_gap != 0)
                chk(cyc - strobe_cyc == exp_gap, gap_req, "step length",
                    cyc - strobe_cyc, exp_gap);
            gap_arm    = 1;
            strobe_cyc = cyc;
            last_seen  = int'(sh_addr);
            n_strobe++;
        end
        prev_s    = sh_strobe;
        prev_code = code_out;
    end

    task automatic push_run(input int start, input int n, input string r);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            int ch = (start + i) % CH;
            e.a = 5'(ch);
            e.c = mem[ch];
            e.r = r;
            q.push_back(e);
        end
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        #1;
    endtask

    task automatic fs_pulse();
        @(posedge clk); #1 frame_start = 1'b1;
        @(posedge clk); #1 frame_start = 1'b0;
    endtask

    task automatic fe_pulse();
        @(posedge clk); #1 frame_end = 1'b1;
        fe_cyc = cyc;
        @(posedge clk); #1 frame_end = 1'b0;
    endtask

    // Reset, then the fill pass (R1, R2, R3); noise adds frames during it.
    task automatic do_fill(input bit noise);
        @(posedge clk); #1 rst_n = 1'b0;
        ext_sel_pin = 1'b1;
        ext_run = 0;
        gap_arm = 0;
        exp_gap = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b1, "R1", "busy in reset", int'(busy), 1);
        chk(sh_strobe == 1'b0, "R1", "strobe in reset", int'(sh_strobe), 0);
        chk(code_out == 12'h4F3, "R1", "code in reset", int'(code_out), 'h4F3);
        for (int i = 0; i < CH; i++) begin
            exp_t e;
            e.a = 5'(i);
            e.c = 12'h4F3;
            e.r = "R2";
            q.push_back(e);
        end
        @(posedge clk); #1 rst_n = 1'b1;
        gap_req = "R3";
        exp_gap = DIV;
        if (noise) begin
            while (q.size() > 26) @(negedge clk);
            last_addr = 5'd9;
            imm_pin = 1'b1;
            fs_pulse();
            repeat (4) @(posedge clk);
            fe_pulse();
            #1 imm_pin = 1'b0;
            chk(busy == 1'b1, "R2", "busy mid-fill", int'(busy), 1);
        end
        drain();
        chk(busy == 1'b0, "R2", "busy after fill", int'(busy), 0);
        chk(last_seen == CH - 1, "R3", "last fill channel", last_seen, CH - 1);
        @(posedge clk); #1 ext_sel_pin = 1'b0;
        gap_arm = 0;
        exp_gap = 0;
    endtask

    // Immediate update of one channel (R8, R9).
    task automatic imm_test(input bit via_pin, input int tgt, input logic [11:0] val);
        int k;
        int base;
        exp_t e;
        exp_gap = 0;
        k = (last_seen + 1) % CH;
        fs_pulse();
        base = n_strobe;
        repeat (3 * DIV) @(posedge clk);
        chk(n_strobe == base, "R8", "strobes while paused", n_strobe - base, 0);
        mem[tgt] = val;
        last_addr = 5'(tgt);
        if (via_pin) imm_pin = 1'b1; else imm_bit = 1'b1;
        fe_pulse();
        imm_pin = 1'b0;
        imm_bit = 1'b0;
        e.a = 5'(tgt);
        e.c = val;
        e.r = "R9";
        q.push_back(e);
        drain();
        chk(strobe_cyc - fe_cyc <= 2 * DIV + 1, "R9", "immediate latency",
            strobe_cyc - fe_cyc, 2 * DIV + 1);
        push_run(k, 34, "R9");
        drain();
    endtask

    // Burst load of several channels (R8, R10).
    task automatic burst_test();
        int k;
        int base;
        exp_gap = 0;
        k = (last_seen + 1) % CH;
        fs_pulse();
        base = n_strobe;
        repeat (2 * DIV) @(posedge clk);
        mem[k] = 12'hA5C;
        mem[(k + 5) % CH] = 12'h0FE;
        mem[(k + 31) % CH] = 12'hFFF;
        last_addr = 5'((k + 5) % CH);
        repeat (2 * DIV) @(posedge clk);
        chk(n_strobe == base, "R8", "strobes during burst", n_strobe - base, 0);
        fe_pulse();
        push_run(k, CH, "R10");
        drain();
        chk(strobe_cyc - fe_cyc <= 33 * DIV + 1, "R10", "burst pass length",
            strobe_cyc - fe_cyc, 33 * DIV + 1);
    endtask

    initial begin
        int base;
        for (int i = 0; i < CH; i++) mem[i] = 12'((i * 113 + 256) & 'hFFF);

        do_fill(1'b0);

        // Normal walk with wrap (R4) and internal step length (R6).
        gap_req = "R6";
        exp_gap = DIV;
        gap_arm = 0;
        push_run((last_seen + 1) % CH, 40, "R4");
        drain();

        imm_test(1'b1, 20, 12'h123);
        imm_test(1'b0, 3, 12'hC75);
        burst_test();

        // External step clock via the serial bit (R7).
        ext_run = 1;
        @(posedge clk); #1 ext_sel_bit = 1'b1;
        gap_req = "R7";
        exp_gap = EXT_GAP;
        gap_arm = 0;
        push_run((last_seen + 1) % CH, 10, "R7");
        drain();
        ext_run = 0;
        base = n_strobe;
        repeat (20 * DIV) @(posedge clk);
        chk(n_strobe == base, "R7", "strobes with stopped clock", n_strobe - base, 0);

        // External step clock via the pin (R7).
        #1 ext_sel_bit = 1'b0;
        ext_sel_pin = 1'b1;
        ext_run = 1;
        gap_arm = 0;
        push_run((last_seen + 1) % CH, 6, "R7");
        drain();

        // Back to the internal divider (R6).
        @(posedge clk); #1 ext_sel_pin = 1'b0;
        ext_run = 0;
        gap_req = "R6";
        exp_gap = DIV;
        gap_arm = 0;
        push_run((last_seen + 1) % CH, 5, "R6");
        drain();

        // Reset in mid-run, with frames during the fill pass (R1, R2, R3).
        do_fill(1'b1);
        push_run((last_seen + 1) % CH, 8, "R4");
        drain();

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R4 watchdog: actual %0d cycles expected below %0d", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule